// File: doc/BRIEF.md
# Head Fault Flag Controller

This block drives the shared fault flag of a multi-head disk preamplifier. The flag line is wired between several devices, so its resting level and its fault level depend on what the device is doing. When idle, the flag rests high. During a read, a fault pulls it low. During a write, a fault drives it high. The servo and analog test modes hold it at a fixed level. The thermal-asperity test mode shows only asperity events.

The block takes the operating mode, a configuration override bit, the 4-bit head code and five raw fault indications from analog detectors. The fault indications are asynchronous. Each one passes through a synchronizer before the block uses it. A head code outside the populated range is treated as a fault. In read mode such a code also makes head 0 the effective head.

Once the last fault is gone, the flag keeps showing the fault for a programmable number of clock cycles. When the device enters write mode, the flag is held low for a blanking window that covers the switching transient.

Top module: `head_fault_flag`

## Requirements
- R1: Sleep (mode 0), standby (mode 1), analog test (mode 4) and the reserved code 7 drive the flag high on the next edge, whatever the faults are. After reset the flag is high and the effective head is 0.
- R2: In read mode (mode 2) with override 0, a counted fault makes the flag low. With override 1 the flag is high even when a fault is present.
- R3: In write mode (mode 3) with override 0, a counted fault makes the flag high. With override 1 the flag is low.
- R4: In read mode the counted faults are low supply, reference fault and an invalid head code. Write-head faults, slow write data and asperity events leave the flag high.
- R5: In write mode the counted faults are low supply, reference fault, write-head fault, slow write data and an invalid head code. An asperity event leaves the flag low.
- R6: Head codes at or above NUM_HEADS (10 to 15 by default) count as a fault. One edge after the code is applied, effHead is 0 if the mode is read with an invalid code. In every other case effHead equals the code.
- R7: A synchronized fault input may drop after being seen. The flag stays at its fault level through the first HOLD_CYCLES+1 rising edges after the drop. It returns to its safe level on edge HOLD_CYCLES+3. Any new fault restarts this delay.
- R8: When the mode changes to write, the flag is held low through the first BLANK_CYCLES+1 rising edges. A fault that is still present raises the flag on the next edge.
- R9: In thermal-asperity test mode (mode 5) the flag is high and an asperity event pulls it low. The override bit and all other faults have no effect in this mode.
- R10: In servo mode (mode 6) the flag is low.
- R11: A raw fault input reaches the flag on the third rising edge after it is applied and not earlier. This is caused by two synchronizer stages and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low reset |
| opMode | input | 3 | Operating mode code |
| overrideSafe | input | 1 | Configuration bit that forces the mode's safe level in read and write modes |
| headCode | input | HEAD_W | Requested head |
| lowSupplyRaw | input | 1 | Low supply detector, asynchronous |
| refFaultRaw | input | 1 | Reference resistor fault, asynchronous |
| wrHeadFaultRaw | input | 1 | Write head open or shorted, asynchronous |
| slowDataRaw | input | 1 | Write data frequency too low, asynchronous |
| asperityRaw | input | 1 | Thermal asperity event, asynchronous |
| flagOut | output | 1 | Fault flag level |
| effHead | output | HEAD_W | Effective head after remapping |

## Verification
The assertions assume that the mode, override bit and head code are register outputs that are stable for each whole clock cycle, and that only the five fault indications arrive asynchronously. The bench drives every input at the falling clock edge. Before each check it leaves a settling gap longer than the blanking window plus the release delay, so a steady-state check is never mixed up with a transient from an earlier step. The timing checks then apply a single input change on a known edge and sample at the exact edge counts stated in R7, R8 and R11.

// File: rtl/hff_pkg.sv
package hff_pkg;

  typedef enum logic [2:0] {
    MODE_SLEEP   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_READ    = 3'd2,
    MODE_WRITE   = 3'd3,
    MODE_ATEST   = 3'd4,
    MODE_TAS     = 3'd5,
    MODE_SERVO   = 3'd6,
    MODE_RSVD    = 3'd7
  } opMode_e;

  // fault vector bit positions
  localparam int FLT_LOW_SUPPLY = 0;
  localparam int FLT_REF        = 1;
  localparam int FLT_WR_HEAD    = 2;
  localparam int FLT_SLOW_DATA  = 3;
  localparam int FLT_ASPERITY   = 4;
  localparam int FLT_BAD_HEAD   = 5;
  localparam int NUM_RAW_FLT    = 5;
  localparam int NUM_FLT        = 6;

  localparam logic [NUM_FLT-1:0] READ_MASK  =
    (NUM_FLT'(1) << FLT_LOW_SUPPLY) | (NUM_FLT'(1) << FLT_REF) | (NUM_FLT'(1) << FLT_BAD_HEAD);
  localparam logic [NUM_FLT-1:0] WRITE_MASK =
    READ_MASK | (NUM_FLT'(1) << FLT_WR_HEAD) | (NUM_FLT'(1) << FLT_SLOW_DATA);
  localparam logic [NUM_FLT-1:0] TAS_MASK   = NUM_FLT'(1) << FLT_ASPERITY;

  typedef enum logic [1:0] {
    OUT_FORCE_HIGH,
    OUT_FORCE_LOW,
    OUT_FAULT_LOW,
    OUT_FAULT_HIGH
  } outClass_e;

  typedef struct packed {
    logic [NUM_FLT-1:0] faultMask;
    outClass_e          outClass;
    logic               holdClear;
    logic               remapHead;
  } ctrlStrobe_t;

endpackage

// File: rtl/hff_sync.sv
module hff_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hff_ctrl.sv
module hff_ctrl
  import hff_pkg::*;
#(
  parameter int BLANK_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  opMode_e     opMode,
  input  logic        overrideSafe,
  output ctrlStrobe_t strobe
);

  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);

  opMode_e            modeQ;
  logic [BLANK_W-1:0] blankCnt;
  logic               writeEntry;
  logic               blanking;

  assign writeEntry = (opMode == MODE_WRITE) && (modeQ != MODE_WRITE);
  assign blanking   = writeEntry || (blankCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_SLEEP;
      blankCnt <= '0;
    end else begin
      modeQ <= opMode;
      if (writeEntry) begin
        blankCnt <= BLANK_W'(BLANK_CYCLES);
      end else if (opMode != MODE_WRITE) begin
        blankCnt <= '0;
      end else if (blankCnt != '0) begin
        blankCnt <= blankCnt - BLANK_W'(1);
      end
    end
  end

  always_comb begin
    strobe.faultMask = '0;
    strobe.outClass  = OUT_FORCE_HIGH;
    strobe.remapHead = 1'b0;
    case (opMode)
      MODE_READ: begin
        strobe.remapHead = 1'b1;
        if (!overrideSafe) begin
          strobe.faultMask = READ_MASK;
          strobe.outClass  = OUT_FAULT_LOW;
        end
      end
      MODE_WRITE: begin
        strobe.outClass = OUT_FORCE_LOW;
        if (!overrideSafe && !blanking) begin
          strobe.faultMask = WRITE_MASK;
          strobe.outClass  = OUT_FAULT_HIGH;
        end
      end
      MODE_TAS: begin
        strobe.faultMask = TAS_MASK;
        strobe.outClass  = OUT_FAULT_LOW;
      end
      MODE_SERVO: begin
        strobe.outClass = OUT_FORCE_LOW;
      end
      default: begin
        strobe.outClass = OUT_FORCE_HIGH;
      end
    endcase
    strobe.holdClear = (strobe.faultMask == '0);
  end

endmodule

// File: rtl/hff_datapath.sv
module hff_datapath
  import hff_pkg::*;
#(
  parameter int HOLD_CYCLES = 40,
  parameter int HEAD_W      = 4,
  parameter int NUM_HEADS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [NUM_RAW_FLT-1:0] rawFault,
  input  logic [HEAD_W-1:0]      headCode,
  output logic                   flagOut,
  output logic [HEAD_W-1:0]      effHead
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [NUM_RAW_FLT-1:0] syncFault;
  logic [NUM_FLT-1:0]     faultVec;
  logic                   headBad;
  logic                   faultNow;
  logic                   unsafe;
  logic [HOLD_W-1:0]      holdCnt;
  logic                   flagNext;

  hff_sync #(
    .WIDTH  (NUM_RAW_FLT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawFault),
    .dout (syncFault)
  );

  assign headBad  = (headCode >= HEAD_W'(NUM_HEADS));
  assign faultVec = {headBad, syncFault};
  assign faultNow = |(faultVec & strobe.faultMask);
  assign unsafe   = faultNow || (holdCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.holdClear) begin
      holdCnt <= '0;
    end else if (faultNow) begin
      holdCnt <= HOLD_W'(HOLD_CYCLES);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  always_comb begin
    case (strobe.outClass)
      OUT_FORCE_HIGH: flagNext = 1'b1;
      OUT_FORCE_LOW:  flagNext = 1'b0;
      OUT_FAULT_LOW:  flagNext = !unsafe;
      default:        flagNext = unsafe;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOut <= 1'b1;
      effHead <= '0;
    end else begin
      flagOut <= flagNext;
      effHead <= (strobe.remapHead && headBad) ? '0 : headCode;
    end
  end

endmodule

// File: rtl/head_fault_flag.sv
module head_fault_flag
  import hff_pkg::*;
#(
  parameter int HOLD_CYCLES  = 40,
  parameter int BLANK_CYCLES = 10,
  parameter int HEAD_W       = 4,
  parameter int NUM_HEADS    = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opMode,
  input  logic              overrideSafe,
  input  logic [HEAD_W-1:0] headCode,
  input  logic              lowSupplyRaw,
  input  logic              refFaultRaw,
  input  logic              wrHeadFaultRaw,
  input  logic              slowDataRaw,
  input  logic              asperityRaw,
  output logic              flagOut,
  output logic [HEAD_W-1:0] effHead
);

  ctrlStrobe_t            strobe;
  logic [NUM_RAW_FLT-1:0] rawFault;

  always_comb begin
    rawFault                 = '0;
    rawFault[FLT_LOW_SUPPLY] = lowSupplyRaw;
    rawFault[FLT_REF]        = refFaultRaw;
    rawFault[FLT_WR_HEAD]    = wrHeadFaultRaw;
    rawFault[FLT_SLOW_DATA]  = slowDataRaw;
    rawFault[FLT_ASPERITY]   = asperityRaw;
  end

  hff_ctrl #(
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .opMode       (opMode_e'(opMode)),
    .overrideSafe (overrideSafe),
    .strobe       (strobe)
  );

  hff_datapath #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .HEAD_W      (HEAD_W),
    .NUM_HEADS   (NUM_HEADS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rawFault (rawFault),
    .headCode (headCode),
    .flagOut  (flagOut),
    .effHead  (effHead)
  );

endmodule

// File: rtl/head_fault_flag_chk.sv
module head_fault_flag_chk
  import hff_pkg::*;
#(
  parameter int HEAD_W    = 4,
  parameter int NUM_HEADS = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opMode,
  input logic              overrideSafe,
  input logic [HEAD_W-1:0] headCode,
  input logic              flagOut,
  input logic [HEAD_W-1:0] effHead
);

  logic idleMode;
  assign idleMode = (opMode == MODE_SLEEP) || (opMode == MODE_STANDBY) ||
                    (opMode == MODE_ATEST) || (opMode == MODE_RSVD);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    idleMode |=> flagOut); // R1

  AST_READ_OVERRIDE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_READ && overrideSafe) |=> flagOut); // R2

  AST_WRITE_OVERRIDE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_WRITE && overrideSafe) |=> !flagOut); // R3

  AST_HEAD_REMAP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_READ && headCode >= HEAD_W'(NUM_HEADS)) |=> (effHead == '0)); // R6

  AST_HEAD_PASS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (headCode < HEAD_W'(NUM_HEADS)) |=> (effHead == $past(headCode))); // R6

  AST_WRITE_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_WRITE && $past(opMode) != MODE_WRITE) |=> !flagOut); // R8

  AST_SERVO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_SERVO) |=> !flagOut); // R10

endmodule

bind head_fault_flag head_fault_flag_chk #(
  .HEAD_W    (HEAD_W),
  .NUM_HEADS (NUM_HEADS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opMode       (opMode),
  .overrideSafe (overrideSafe),
  .headCode     (headCode),
  .flagOut      (flagOut),
  .effHead      (effHead)
);

// File: tb/head_fault_flag_tb.sv
module head_fault_flag_tb;

  localparam int HOLD  = 40;
  localparam int BLANK = 10;
  localparam int HW    = 4;
  localparam int NH    = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    opMode = 3'd0;
  logic          overrideSafe = 1'b0;
  logic [HW-1:0] headCode = '0;
  logic          lowSupplyRaw = 1'b0;
  logic          refFaultRaw = 1'b0;
  logic          wrHeadFaultRaw = 1'b0;
  logic          slowDataRaw = 1'b0;
  logic          asperityRaw = 1'b0;
  logic          flagOut;
  logic [HW-1:0] effHead;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  head_fault_flag #(
    .HOLD_CYCLES  (HOLD),
    .BLANK_CYCLES (BLANK),
    .HEAD_W       (HW),
    .NUM_HEADS    (NH),
    .SYNC_STAGES  (2)
  ) u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .opMode         (opMode),
    .overrideSafe   (overrideSafe),
    .headCode       (headCode),
    .lowSupplyRaw   (lowSupplyRaw),
    .refFaultRaw    (refFaultRaw),
    .wrHeadFaultRaw (wrHeadFaultRaw),
    .slowDataRaw    (slowDataRaw),
    .asperityRaw    (asperityRaw),
    .flagOut        (flagOut),
    .effHead        (effHead)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // fault index: 0 low supply, 1 reference, 2 write head, 3 slow data,
  // 4 asperity, 5 invalid head code (12), 6 none
  task automatic apply(input int m, input int o, input int f);
    opMode         = 3'(m);
    overrideSafe   = o[0];
    headCode       = (f == 5) ? HW'(12) : '0;
    lowSupplyRaw   = (f == 0);
    refFaultRaw    = (f == 1);
    wrHeadFaultRaw = (f == 2);
    slowDataRaw    = (f == 3);
    asperityRaw    = (f == 4);
  endtask

  function automatic int expFlag(input int m, input int o, input int f);
    bit rf;
    bit wf;
    rf = (f == 0) || (f == 1) || (f == 5);
    wf = (f <= 3) || (f == 5);
    case (m)
      2: return o ? 1 : (rf ? 0 : 1);
      3: return o ? 0 : (wf ? 1 : 0);
      5: return (f == 4) ? 0 : 1;
      6: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic string reqOf(input int m);
    case (m)
      2: return "R2 R4";
      3: return "R3 R5";
      5: return "R9";
      6: return "R10";
      default: return "R1";
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam int WATCHDOG_CYCLES = 150000;

  initial begin
    tick(3);
    // R1: reset state
    check(flagOut, 1, "R1 reset flag");
    check(effHead, 0, "R1 reset head");
    rstN = 1'b1;
    tick(2);

    // steady-state sweep over mode, override and fault source
    for (int m = 0; m < 8; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int f = 0; f < 7; f++) begin
          apply(m, o, 6);
          tick(BLANK + HOLD + 8);
          check(flagOut, expFlag(m, o, 6), reqOf(m));
          apply(m, o, f);
          tick(6);
          check(flagOut, expFlag(m, o, f), reqOf(m));
        end
      end
    end

    // R6: head code sweep in every mode
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 16; c++) begin
        opMode   = 3'(m);
        headCode = HW'(c);
        tick(1);
        check(effHead, (m == 2 && c >= NH) ? 0 : c, "R6");
      end
    end

    // R11: synchronizer latency in read mode
    apply(2, 0, 6);
    tick(BLANK + HOLD + 8);
    lowSupplyRaw = 1'b1;
    tick(2);
    check(flagOut, 1, "R11 too early");
    tick(1);
    check(flagOut, 0, "R11 third edge");

    // R7: release delay after the fault drops
    tick(5);
    lowSupplyRaw = 1'b0;
    tick(HOLD + 1);
    check(flagOut, 0, "R7 still held");
    tick(2);
    check(flagOut, 1, "R7 released");

    // R7: a new fault restarts the delay
    lowSupplyRaw = 1'b1;
    tick(5);
    lowSupplyRaw = 1'b0;
    tick(HOLD - 5);
    refFaultRaw = 1'b1;
    tick(1);
    refFaultRaw = 1'b0;
    tick(HOLD + 2);
    check(flagOut, 0, "R7 restart held");
    tick(2);
    check(flagOut, 1, "R7 restart released");

    // R8: blanking on write entry with a standing invalid head fault
    apply(2, 0, 6);
    tick(BLANK + HOLD + 8);
    opMode   = 3'd3;
    headCode = HW'(12);
    tick(BLANK + 1);
    check(flagOut, 0, "R8 blanked");
    tick(1);
    check(flagOut, 1, "R8 detection on");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule